// File: doc/BRIEF.md
# Minimizer k-mer Bucketing Unit

This unit consumes a stream of 2-bit nucleotide codes, one per handshake, and slides a window of K symbols along each read. Once the window holds K consecutive valid symbols of the current read, it emits the window contents as a k-mer, then emits one more k-mer for every further valid symbol of that read. A start-of-read flag restarts the window. A symbol marked as not one of the four bases also empties the window, so no emitted k-mer ever straddles an unknown base.

For each k-mer the unit picks a bucket key. The key is the smallest numeric value among the K-M+1 overlapping substrings of length M inside the window. The key is then placed on a destination cube by the affine hash (HASH_A*key + HASH_B) mod HASH_P. A flag reports whether that cube is the unit's own cube (OWN_CUBE) or a remote one that needs transport across the network. Results leave on a valid/ready stream. When the consumer stalls, the input side is held back, so no k-mer is lost or repeated.

Top module: `kmer_bucketer`

## Requirements
- R1: After reset, out_valid_o is 0 and sym_ready_o is 1.
- R2: Each accepted valid symbol that is the K-th or a later consecutive valid symbol of the current read yields exactly one k-mer, and k-mers leave in acceptance order. kmer_o holds the last K symbols, with the oldest in bits [2K-1:2K-2] and the newest in bits [1:0]. Codes are A=0, C=1, G=2, T=3.
- R3: bucket_o is the minimum over j=0..K-M of kmer_o[2(K-j)-1 -: 2M]. Each substring is read with its earliest symbol most significant.
- R4: cube_o equals (HASH_A*bucket_o + HASH_B) mod HASH_P, so it is always below HASH_P.
- R5: local_o is 1 exactly when cube_o equals OWN_CUBE.
- R6: An accepted symbol with sym_first_i=1 becomes the first symbol of a new read. Symbols before it contribute to no later k-mer.
- R7: An accepted symbol with sym_bad_i=1 produces nothing and empties the window. This holds even when sym_first_i is also set. The next valid symbol counts as the first of a new run.
- R8: While out_valid_o=1 and out_ready_i=0, all outputs stay unchanged in the next cycle. sym_ready_o is 0 only when an output is stalled this way and another completed k-mer is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sym_valid_i | input | 1 | Symbol present |
| sym_ready_o | output | 1 | Symbol accepted this cycle when valid |
| sym_i | input | 2 | Nucleotide code A=0, C=1, G=2, T=3 |
| sym_first_i | input | 1 | Symbol starts a new read |
| sym_bad_i | input | 1 | Symbol is not a base; restarts the window |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Consumer takes the result |
| kmer_o | output | 2*K | Window contents, oldest symbol in the top bits |
| bucket_o | output | 2*M | Minimizer value used as bucket key |
| cube_o | output | $clog2(HASH_P) | Destination cube |
| local_o | output | 1 | Destination cube is the own cube |

## Verification
The bench builds the unit with K=8, M=3, HASH_A=7, HASH_B=2, HASH_P=5 and OWN_CUBE=3. Reads are short, so a window fills within a few symbols. Random resets by read start and by unknown bases therefore land at every fill level, including one symbol short of a full window. The 6-bit bucket space is small enough that random data reaches every cube value, and both local and remote outcomes occur often. A modulus that is not a power of two exercises a real remainder rather than a bit slice. Random consumer stalls together with a back-to-back symbol stream push the input stall path and output holding into frequent use.

// File: rtl/kmer_bucket_pkg.sv
package kmer_bucket_pkg;
  localparam int unsigned SYM_W = 2;
  typedef enum logic [SYM_W-1:0] {NT_A = 2'd0, NT_C = 2'd1, NT_G = 2'd2, NT_T = 2'd3} nt_e;
endpackage

// File: rtl/kmer_window.sv
module kmer_window
  import kmer_bucket_pkg::*;
#(
  parameter int unsigned K = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sym_valid_i,
  input  logic [SYM_W-1:0]   sym_i,
  input  logic               sym_first_i,
  input  logic               sym_bad_i,
  output logic               sym_ready_o,
  input  logic               take_i,
  output logic [SYM_W*K-1:0] win_o,
  output logic               pend_o
);
  localparam int unsigned CNT_W = $clog2(K + 1);
  localparam int unsigned WIN_W = SYM_W * K;

  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             pend_q, accept, full_nxt;

  assign sym_ready_o = ~pend_q | take_i;
  assign accept      = sym_valid_i & sym_ready_o;

  always_comb begin
    if (sym_first_i)                 cnt_nxt = CNT_W'(1);
    else if (cnt_q == CNT_W'(K))     cnt_nxt = cnt_q;
    else                             cnt_nxt = cnt_q + CNT_W'(1);
  end

  assign full_nxt = accept & ~sym_bad_i & (cnt_nxt == CNT_W'(K));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (accept) begin
        if (sym_bad_i) begin
          cnt_q <= '0;
        end else begin
          win_q <= {win_q[WIN_W-SYM_W-1:0], sym_i};
          cnt_q <= cnt_nxt;
        end
      end
      pend_q <= full_nxt | (pend_q & ~take_i);
    end
  end

  assign win_o  = win_q;
  assign pend_o = pend_q;

  // a waiting k-mer always sits in a completely filled window
  p_pend_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (cnt_q == CNT_W'(K)));
  // a bad symbol never creates a waiting k-mer
  p_bad_no_pend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && sym_bad_i) |=> !pend_q);
endmodule

// File: rtl/kmer_minimizer.sv
module kmer_minimizer
  import kmer_bucket_pkg::*;
#(
  parameter int unsigned K = 32,
  parameter int unsigned M = 7
) (
  input  logic [SYM_W*K-1:0] win_i,
  output logic [SYM_W*M-1:0] min_o
);
  localparam int unsigned NPOS  = K - M + 1;
  localparam int unsigned MER_W = SYM_W * M;

  logic [MER_W-1:0] mer [NPOS];

  for (genvar j = 0; j < NPOS; j++) begin : g_mer
    assign mer[j] = win_i[SYM_W*(K-j)-1 -: MER_W];
  end

  // strict compare keeps the leftmost of equal values
  always_comb begin
    min_o = mer[0];
    for (int j = 1; j < NPOS; j++) begin
      if (mer[j] < min_o) min_o = mer[j];
    end
  end
endmodule

// File: rtl/kmer_cube_hash.sv
module kmer_cube_hash #(
  parameter int unsigned BKT_W  = 14,
  parameter int unsigned CUBE_W = 4,
  parameter int unsigned HASH_A = 37,
  parameter int unsigned HASH_B = 11,
  parameter int unsigned HASH_P = 16
) (
  input  logic [BKT_W-1:0]  bucket_i,
  output logic [CUBE_W-1:0] cube_o
);
  localparam int unsigned PROD_W = BKT_W + 33;

  logic [PROD_W-1:0] lin, rem;

  assign lin    = PROD_W'(HASH_A) * PROD_W'(bucket_i) + PROD_W'(HASH_B);
  assign rem    = lin % PROD_W'(HASH_P);
  assign cube_o = rem[CUBE_W-1:0];
endmodule

// File: rtl/kmer_bucketer.sv
module kmer_bucketer
  import kmer_bucket_pkg::*;
#(
  parameter int unsigned K        = 32,
  parameter int unsigned M        = 7,
  parameter int unsigned HASH_A   = 37,
  parameter int unsigned HASH_B   = 11,
  parameter int unsigned HASH_P   = 16,
  parameter int unsigned OWN_CUBE = 0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sym_valid_i,
  output logic                       sym_ready_o,
  input  logic [1:0]                 sym_i,
  input  logic                       sym_first_i,
  input  logic                       sym_bad_i,
  output logic                       out_valid_o,
  input  logic                       out_ready_i,
  output logic [2*K-1:0]             kmer_o,
  output logic [2*M-1:0]             bucket_o,
  output logic [$clog2(HASH_P)-1:0]  cube_o,
  output logic                       local_o
);
  localparam int unsigned KMER_W = SYM_W * K;
  localparam int unsigned BKT_W  = SYM_W * M;
  localparam int unsigned CUBE_W = $clog2(HASH_P);
  localparam int unsigned NPOS   = K - M + 1;

  logic [KMER_W-1:0] win;
  logic [BKT_W-1:0]  min_val;
  logic [CUBE_W-1:0] cube_val;
  logic              pend, take;

  assign take = pend & (~out_valid_o | out_ready_i);

  kmer_window #(.K(K)) u_window (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sym_valid_i (sym_valid_i),
    .sym_i       (sym_i),
    .sym_first_i (sym_first_i),
    .sym_bad_i   (sym_bad_i),
    .sym_ready_o (sym_ready_o),
    .take_i      (take),
    .win_o       (win),
    .pend_o      (pend)
  );

  kmer_minimizer #(.K(K), .M(M)) u_min (
    .win_i (win),
    .min_o (min_val)
  );

  kmer_cube_hash #(
    .BKT_W(BKT_W), .CUBE_W(CUBE_W),
    .HASH_A(HASH_A), .HASH_B(HASH_B), .HASH_P(HASH_P)
  ) u_hash (
    .bucket_i (min_val),
    .cube_o   (cube_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      kmer_o      <= '0;
      bucket_o    <= '0;
      cube_o      <= '0;
      local_o     <= 1'b0;
    end else begin
      out_valid_o <= take | (out_valid_o & ~out_ready_i);
      if (take) begin
        kmer_o   <= win;
        bucket_o <= min_val;
        cube_o   <= cube_val;
        local_o  <= (cube_val == CUBE_W'(OWN_CUBE));
      end
    end
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(kmer_o) &&
      $stable(bucket_o) && $stable(cube_o) && $stable(local_o)));
  p_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_ready_o |-> (out_valid_o && !out_ready_i));
  p_cube_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (32'(cube_o) < HASH_P));
  for (genvar j = 0; j < NPOS; j++) begin : g_chk
    p_bucket_min_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |-> (bucket_o <= kmer_o[SYM_W*(K-j)-1 -: BKT_W]));
  end
endmodule

// File: tb/kmer_bucketer_bench.sv
module kmer_bucketer_bench;
  localparam int K = 8, M = 3, A = 7, B = 2, P = 5, OWN = 3;
  localparam int KW = 2 * K, BW = 2 * M, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sym_valid = 1'b0, sym_first = 1'b0, sym_bad = 1'b0, out_ready = 1'b0;
  logic [1:0] sym = '0;
  logic sym_ready_o, out_valid_o, local_o;
  logic [KW-1:0] kmer_o;
  logic [BW-1:0] bucket_o;
  logic [CW-1:0] cube_o;

  always #4 clk = ~clk;

  kmer_bucketer #(.K(K), .M(M), .HASH_A(A), .HASH_B(B), .HASH_P(P), .OWN_CUBE(OWN))
  u_kmer_bucketer (
    .clk_i(clk), .rst_ni(rst_n), .sym_valid_i(sym_valid), .sym_ready_o(sym_ready_o),
    .sym_i(sym), .sym_first_i(sym_first), .sym_bad_i(sym_bad),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready), .kmer_o(kmer_o),
    .bucket_o(bucket_o), .cube_o(cube_o), .local_o(local_o)
  );

  int checks = 0, fails = 0, emitted = 0;
  bit done = 0;
  logic [KW-1:0] rwin = '0;
  int rcnt = 0;
  logic [KW-1:0] exp_q[$];
  bit stall_prev = 0;
  logic [KW-1:0] s_kmer;
  logic [BW-1:0] s_bkt;
  logic [CW-1:0] s_cube;
  logic s_loc;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int ref_bucket(logic [KW-1:0] km);
    int best = 1 << BW;
    for (int j = 0; j <= K - M; j++) begin
      int v = int'((km >> (2 * (K - M - j))) & ((1 << BW) - 1));
      if (v < best) best = v;
    end
    return best;
  endfunction

  function automatic int ref_cube(int b);
    return (A * b + B) % P;
  endfunction

  task automatic step(bit v, bit [1:0] s, bit f, bit b, bit r, output bit acc);
    logic [KW-1:0] e;
    sym_valid = v; sym = s; sym_first = f; sym_bad = b; out_ready = r;
    #3;
    acc = v && sym_ready_o;
    if (stall_prev) begin
      chk("R8 hold valid", out_valid_o, 1);
      chk("R8 hold kmer", kmer_o, s_kmer);
      chk("R8 hold bucket", bucket_o, s_bkt);
      chk("R8 hold cube", {s_loc, cube_o} == {local_o, s_cube} ? 1 : 0, 1);
    end
    if (!sym_ready_o) chk("R8 stall cause", out_valid_o && !out_ready, 1);
    if (out_valid_o && out_ready) begin
      emitted++;
      if (exp_q.size() == 0) chk("R2 unexpected kmer", 1, 0);
      else begin
        e = exp_q.pop_front();
        chk("R2 kmer", kmer_o, e);
        chk("R3 bucket", bucket_o, ref_bucket(e));
        chk("R4 cube", cube_o, ref_cube(ref_bucket(e)));
        chk("R5 local", local_o, ref_cube(ref_bucket(e)) == OWN);
      end
    end
    stall_prev = out_valid_o && !out_ready;
    s_kmer = kmer_o; s_bkt = bucket_o; s_cube = cube_o; s_loc = local_o;
    if (acc) begin
      if (b) rcnt = 0;
      else begin
        rwin = {rwin[KW-3:0], s};
        rcnt = f ? 1 : (rcnt < K ? rcnt + 1 : K);
        if (rcnt == K) exp_q.push_back(rwin);
      end
    end
    @(negedge clk);
  endtask

  task automatic send(bit [1:0] s, bit f, bit b);
    bit acc = 0;
    while (!acc) step(1, s, f, b, 1, acc);
  endtask

  task automatic drain();
    bit acc;
    repeat (K + 4) step(0, 0, 0, 0, 1, acc);
  endtask

  initial begin
    int base;
    bit acc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", out_valid_o, 0);
    chk("R1 sym_ready after reset", sym_ready_o, 1);

    // R6: two reads of K-1 symbols give nothing; one more symbol gives one k-mer
    base = emitted;
    send(2'd2, 1, 0);
    for (int i = 0; i < K - 2; i++) send(2'(i), 0, 0);
    send(2'd1, 1, 0);
    for (int i = 0; i < K - 2; i++) send(2'(3 - i), 0, 0);
    drain();
    chk("R6 no kmer across read start", emitted - base, 0);
    send(2'd0, 0, 0);
    drain();
    chk("R6 first full window", emitted - base, 1);

    // R7: bad symbol (also flagged first) restarts the window
    base = emitted;
    send(2'd3, 1, 0);
    for (int i = 0; i < K - 1; i++) send(2'd1, 0, 0);
    send(2'd0, 1, 1);
    for (int i = 0; i < K - 1; i++) send(2'd2, 0, 0);
    drain();
    chk("R7 bad splits window", emitted - base, 1);
    send(2'd3, 0, 0);
    drain();
    chk("R7 refill after bad", emitted - base, 2);

    // all-T read: largest minimizer; equal m-mers everywhere
    send(2'd3, 1, 0);
    for (int i = 0; i < K + 2; i++) send(2'd3, 0, 0);
    // back-to-back with consumer stalled
    send(2'd0, 1, 0);
    for (int i = 0; i < 2 * K; i++) step(1, 2'($urandom), 0, 0, 0, acc);
    drain();

    // random traffic
    for (int i = 0; i < 6000; i++) begin
      int u = $urandom % 100;
      step(($urandom % 100) < 85, 2'($urandom), u < 4, (u >= 4) && (u < 8),
           ($urandom % 100) < 65, acc);
    end
    drain();
    chk("R2 nothing lost", exp_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule